// File: doc/BRIEF.md
# DDR Controller Configuration Register Slave

This block is the register front end of a DDR2 memory controller, attached to a simple device-control bus: a register number, separate write and read strobes, and 32-bit write and read data. Most configuration sits behind a pointer/window pair. Software writes an index into the pointer register, then reads or writes the window register to reach the internal register at that index.

A small group of registers is decoded directly. Four bank descriptor registers return a fixed word built from each bank's base and size, which are set as parameters at elaboration. Some legacy registers take writes and read back zero.

The only writable internal state is the controller-enable flag in the option register. A write that sets the flag sends a one-cycle map-all request to the bank decoder. A write that clears it sends a one-cycle unmap-all request. A write that leaves the flag unchanged does nothing. Software turns the controller on by writing 0x21 to the pointer and then 0x08000000 to the window.

Top module: `ddr_cfg_regs`

## Requirements
- R1: Direct register 0x10 is the 32-bit pointer. A read returns exactly the last value written to it.
- R2: With the pointer at 0x21, window register 0x11 reaches the option register. A read returns the enable flag in bit 27 and zero in every other bit.
- R3: A window write at pointer 0x21 with bit 27 set, while the flag is clear, sets the flag. map_all_o is high for exactly the one cycle after that write.
- R4: A window write at pointer 0x21 with bit 27 clear, while the flag is set, clears the flag. unmap_all_o is high for exactly the one cycle after that write.
- R5: A write to the option register that leaves bit 27 unchanged gives no pulse and leaves the flag as it was. No pulse appears in a cycle that follows no write.
- R6: Window reads return fixed status words: 0x80000000 at pointer 0x14 or 0x1F, 0x00008001 at pointer 0x40, and 0x02000000 at pointer 0x7A.
- R7: Direct registers 0x40 to 0x43 describe banks 0 to 3, and writes to them are ignored. For a bank whose size is a power of two from 8 to 4096 MiB, a read returns the following word:
  - bit 0 set;
  - bits 15:6 equal to 1024 minus the size in 8 MiB units;
  - bits 31:21 equal to bits 13:3 of the base address in MiB.

  Any other size reads 0. The default banks read 0x0000F801, 0x1000FFC1, 0 and 0.
- R8: Direct registers 0x45, 0x4A, 0x4B, 0x4F and 0x50 read as 0. So do all other unlisted direct registers and unlisted pointer values. Writes to any of them change neither the pointer nor the flag.
- R9: Reset, active low and asynchronous, clears the pointer, the flag and the read data to 0. Both pulse outputs stay low while reset is held.
- R10: Read data appears in the cycle after the read strobe and holds until the next read strobe.
- R11: A window write at a pointer other than 0x21 never changes the flag, even when bit 27 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dcr_num_i | input | NUM_W (10) | Register number |
| dcr_wr_i | input | 1 | Write strobe |
| dcr_rd_i | input | 1 | Read strobe |
| dcr_wdata_i | input | 32 | Write data |
| dcr_rdata_o | output | 32 | Registered read data |
| map_all_o | output | 1 | One-cycle request to map all banks |
| unmap_all_o | output | 1 | One-cycle request to unmap all banks |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it. Read data is due one edge after a read strobe, and a flag pulse is due one edge after the window write that causes it. The bench drives inputs on the falling edge. At each rising edge, a behavioural model takes those inputs and works out what the outputs must show after that edge. On the following falling edge the bench compares both pulse outputs and the held read word against the model. This means a pulse that comes early, comes late or lasts too long is reported in the exact cycle where it differs.

// File: rtl/ddr_cfg_pkg.sv
package ddr_cfg_pkg;
  localparam int unsigned NUM_PTR    = 'h10;
  localparam int unsigned NUM_WIN    = 'h11;
  localparam int unsigned NUM_BANK0  = 'h40;
  localparam logic [31:0] IDX_OPT    = 32'h21;
  localparam int unsigned EN_BIT     = 27;
  localparam logic [31:0] ST_READY   = 32'h8000_0000;
  localparam logic [31:0] ST_BANKCF  = 32'h0000_8001;
  localparam logic [31:0] ST_DLL     = 32'h0200_0000;

  // Encoded bank descriptor; 0 for an unsupported size.
  function automatic logic [31:0] bank_word(int unsigned size_mb, int unsigned base_mb);
    logic [31:0] w;
    int unsigned units;
    w = '0;
    if (size_mb >= 8 && size_mb <= 4096 && (size_mb & (size_mb - 1)) == 0) begin
      units      = 1024 - size_mb / 8;
      w[15:6]    = units[9:0];
      w[31:21]   = 11'((base_mb >> 3) & 'h7FF);
      w[0]       = 1'b1;
    end
    return w;
  endfunction
endpackage

// File: rtl/ddr_bank_words.sv
module ddr_bank_words #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_MB      [NUM_BANKS] = '{256, 8, 24, 0},
  parameter int unsigned BANK_BASE_MB [NUM_BANKS] = '{0, 1024, 0, 0}
) (
  output logic [31:0] word_o [NUM_BANKS]
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign word_o[b] = ddr_cfg_pkg::bank_word(BANK_MB[b], BANK_BASE_MB[b]);
  end
endmodule

// File: rtl/ddr_enable_ctl.sv
module ddr_enable_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic opt_wr_i,
  input  logic opt_en_i,
  output logic en_o,
  output logic map_all_o,
  output logic unmap_all_o
);
  logic en_q, map_q, unmap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else if (opt_wr_i) en_q <= opt_en_i;
  end

  // pulses only on a change of the flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q   <= 1'b0;
      unmap_q <= 1'b0;
    end else begin
      map_q   <= opt_wr_i &&  opt_en_i && !en_q;
      unmap_q <= opt_wr_i && !opt_en_i &&  en_q;
    end
  end

  assign en_o        = en_q;
  assign map_all_o   = map_q;
  assign unmap_all_o = unmap_q;

  // R3
  map_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_q |-> en_q && !$past(en_q));
  // R4
  unmap_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmap_q |-> !en_q && $past(en_q));
  // R3
  map_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_q |=> !map_q);
  // R5
  flag_change_pulses_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q != $past(en_q)) |-> (map_q || unmap_q));
endmodule

// File: rtl/ddr_cfg_regs.sv
module ddr_cfg_regs #(
  parameter int unsigned NUM_W     = 10,
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_MB      [NUM_BANKS] = '{256, 8, 24, 0},
  parameter int unsigned BANK_BASE_MB [NUM_BANKS] = '{0, 1024, 0, 0}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_W-1:0] dcr_num_i,
  input  logic             dcr_wr_i,
  input  logic             dcr_rd_i,
  input  logic [31:0]      dcr_wdata_i,
  output logic [31:0]      dcr_rdata_o,
  output logic             map_all_o,
  output logic             unmap_all_o
);
  import ddr_cfg_pkg::*;
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [31:0] ptr_q, rdata_q, rd_word;
  logic [31:0] bank_words [NUM_BANKS];
  logic        hit_ptr, hit_win, hit_bank, opt_wr, en;
  logic [IDX_W-1:0] bank_idx;

  assign hit_ptr  = dcr_num_i == NUM_W'(NUM_PTR);
  assign hit_win  = dcr_num_i == NUM_W'(NUM_WIN);
  assign hit_bank = dcr_num_i >= NUM_W'(NUM_BANK0) && dcr_num_i < NUM_W'(NUM_BANK0 + NUM_BANKS);
  assign bank_idx = IDX_W'(dcr_num_i - NUM_W'(NUM_BANK0));
  assign opt_wr   = dcr_wr_i && hit_win && ptr_q == IDX_OPT;

  ddr_bank_words #(
    .NUM_BANKS(NUM_BANKS), .BANK_MB(BANK_MB), .BANK_BASE_MB(BANK_BASE_MB)
  ) u_banks (
    .word_o(bank_words)
  );

  ddr_enable_ctl u_en (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .opt_wr_i(opt_wr), .opt_en_i(dcr_wdata_i[EN_BIT]),
    .en_o(en), .map_all_o(map_all_o), .unmap_all_o(unmap_all_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (dcr_wr_i && hit_ptr) ptr_q <= dcr_wdata_i;
  end

  always_comb begin
    rd_word = '0;
    if (hit_ptr) begin
      rd_word = ptr_q;
    end else if (hit_win) begin
      case (ptr_q)
        32'h14, 32'h1F: rd_word = ST_READY;
        IDX_OPT:        rd_word[EN_BIT] = en;
        32'h40:         rd_word = ST_BANKCF;
        32'h7A:         rd_word = ST_DLL;
        default:        rd_word = '0;
      endcase
    end else if (hit_bank) begin
      rd_word = bank_words[bank_idx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (dcr_rd_i) rdata_q <= rd_word;
  end

  assign dcr_rdata_o = rdata_q;

  // R1
  ptr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcr_wr_i && hit_ptr |=> ptr_q == $past(dcr_wdata_i));
  // R8
  unlisted_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcr_rd_i && !hit_ptr && !hit_win && !hit_bank |=> dcr_rdata_o == 32'h0);
  // R5
  no_write_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dcr_wr_i |=> !map_all_o && !unmap_all_o);
  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dcr_rd_i |=> $stable(dcr_rdata_o));
  // R3
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(map_all_o && unmap_all_o));
endmodule

// File: tb/sim_ddr_cfg_regs.sv
module sim_ddr_cfg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  num = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        map_o, unmap_o;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  string cur_tag = "R10";

  always #10 clk = ~clk;

  ddr_cfg_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .dcr_num_i(num), .dcr_wr_i(wr), .dcr_rd_i(rd),
    .dcr_wdata_i(wdata), .dcr_rdata_o(rdata), .map_all_o(map_o), .unmap_all_o(unmap_o)
  );

  // behavioural reference
  logic [31:0] m_ptr, m_rd;
  bit m_en, m_map, m_unmap, m_rd_now;
  string m_tag;

  function automatic logic [31:0] model_read(logic [9:0] n);
    if (n == 10'h10) return m_ptr;
    if (n == 10'h11) begin
      if (m_ptr == 32'h14 || m_ptr == 32'h1F) return 32'h8000_0000;
      if (m_ptr == 32'h21) return m_en ? 32'h0800_0000 : 32'h0;
      if (m_ptr == 32'h40) return 32'h0000_8001;
      if (m_ptr == 32'h7A) return 32'h0200_0000;
      return 32'h0;
    end
    if (n == 10'h40) return 32'h0000_F801;
    if (n == 10'h41) return 32'h1000_FFC1;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_en = 0; m_rd = 0; m_map = 0; m_unmap = 0; m_rd_now = 0;
    end else begin
      m_map = 0; m_unmap = 0; m_rd_now = rd;
      if (rd) begin m_rd = model_read(num); m_tag = cur_tag; end
      if (wr) begin
        if (num == 10'h10) m_ptr = wdata;
        else if (num == 10'h11 && m_ptr == 32'h21) begin
          if (wdata[27] && !m_en) begin m_en = 1; m_map = 1; end
          else if (!wdata[27] && m_en) begin m_en = 0; m_unmap = 1; end
        end
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(map_o == m_map, m_map ? "R3" : "R5", 32'(map_o), 32'(m_map));
      check(unmap_o == m_unmap, m_unmap ? "R4" : "R5", 32'(unmap_o), 32'(m_unmap));
      check(rdata == m_rd, m_rd_now ? m_tag : "R10", rdata, m_rd);
    end
  end

  task automatic wr_reg(logic [9:0] n, logic [31:0] d);
    @(negedge clk); num = n; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(logic [9:0] n, string tag);
    @(negedge clk); num = n; rd = 1; cur_tag = tag;
    @(negedge clk); rd = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(rdata == 0 && !map_o && !unmap_o, "R9", rdata, 32'h0);
    rst_n = 1;
    rd_reg(10'h10, "R9");
    rd_reg(10'h11, "R9");
    // R1 pointer
    wr_reg(10'h10, 32'hDEAD_BEEF); rd_reg(10'h10, "R1");
    wr_reg(10'h10, 32'h0000_0000); rd_reg(10'h10, "R1");
    // R6 status words
    wr_reg(10'h10, 32'h14); rd_reg(10'h11, "R6");
    // R11 window write at non-option pointer
    wr_reg(10'h11, 32'hFFFF_FFFF);
    wr_reg(10'h10, 32'h1F); rd_reg(10'h11, "R6");
    wr_reg(10'h10, 32'h40); rd_reg(10'h11, "R6");
    wr_reg(10'h10, 32'h7A); rd_reg(10'h11, "R6");
    wr_reg(10'h10, 32'h55); rd_reg(10'h11, "R8");
    wr_reg(10'h10, 32'h21); rd_reg(10'h11, "R11");
    // R3 enable sequence
    wr_reg(10'h11, 32'h0800_0000); rd_reg(10'h11, "R2");
    // R5 unchanged writes
    wr_reg(10'h11, 32'h0800_0000);
    wr_reg(10'h11, 32'hFFFF_FFFF); rd_reg(10'h11, "R2");
    // R4 disable
    wr_reg(10'h11, 32'hF7FF_FFFF); rd_reg(10'h11, "R2");
    wr_reg(10'h11, 32'h0); rd_reg(10'h11, "R5");
    // R7 bank words, writes ignored
    for (int b = 0; b < 4; b++) wr_reg(10'(10'h40 + b), 32'h1234_5678);
    for (int b = 0; b < 4; b++) rd_reg(10'(10'h40 + b), "R7");
    // R8 inert and unlisted registers
    wr_reg(10'h10, 32'h21);
    wr_reg(10'h45, 32'h0800_0000); wr_reg(10'h4A, 32'hFFFF_FFFF);
    wr_reg(10'h4B, 32'h1); wr_reg(10'h4F, 32'h2); wr_reg(10'h50, 32'h3);
    wr_reg(10'h3FF, 32'h0800_0000);
    rd_reg(10'h10, "R8"); rd_reg(10'h11, "R8");
    rd_reg(10'h45, "R8"); rd_reg(10'h4A, "R8"); rd_reg(10'h4B, "R8");
    rd_reg(10'h4F, "R8"); rd_reg(10'h50, "R8"); rd_reg(10'h3FF, "R8");
    rd_reg(10'h44, "R8");
    // R10 hold over idle cycles
    rd_reg(10'h41, "R10");
    repeat (5) @(negedge clk);
    // R9 reset mid-run
    wr_reg(10'h11, 32'h0800_0000);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check(rdata == 0 && !map_o && !unmap_o, "R9", rdata, 32'h0);
    rst_n = 1;
    rd_reg(10'h10, "R9"); rd_reg(10'h11, "R9");
    wr_reg(10'h10, 32'h21); rd_reg(10'h11, "R9");
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    wait (cycles > 5000);
    failures++;
    $display("FAIL watchdog actual=%0d expected<5000", cycles);
    finish_run();
  end
endmodule